// File: doc/BRIEF.md
# Dual Read Prefetch Buffer

This block sits between a bus-side read port and the burst read port of an SDRAM controller. It keeps two buffers, each one memory burst long. Each buffer has a block base register and one valid bit per word, and together these act as the tag of a small two-entry cache. A read whose block matches a buffer base, and whose word has its valid bit set, is answered from that buffer without touching memory.

On a miss, the block raises one burst read request with a burst-aligned address. Each returned word is written into the buffer chosen by a fill pointer. In the cycle that the requested word arrives, that word is also loaded into the response slot. The fill pointer flips after every completed burst, so misses fill buffer 0 and buffer 1 in turn.

A write-snoop input reports every write that goes to memory. It clears the valid bit of any buffered copy of that word, so stale data is never returned.

The request and response sides are valid/ready streams. A request is taken only when `rq_valid` and `rq_ready` are both high on a clock edge. The block holds one read at a time: `rq_ready` is low while a miss is in progress or while a response is waiting. A response holds `rs_valid` and `rs_data` steady until `rs_ready` is seen high.

The memory request is also valid/ready, and `mem_req_valid` with its address stays steady until it is accepted. Returned burst words cannot be throttled. They arrive with `mem_rd_valid`, one word per cycle, in ascending word order.

Top module: `rd_prefetch_pair`

## Requirements
- R1: After reset `rq_ready` is 1, `rs_valid` is 0 and `mem_req_valid` is 0. All valid bits are clear, so the first read of any address misses, and the first miss fills buffer 0.
- R2: A read hits when its block number (address bits above the word offset) equals a buffer's base and that word's valid bit is set. A hit raises `rs_valid` in the cycle after acceptance, with the buffered word, and raises no memory request.
- R3: A miss raises exactly one burst request. Its `mem_req_addr` carries the requested block number with the low log2(BURST) bits zero.
- R4: On a miss, the response carries the word at the requested offset within the returned burst. All BURST words are captured, so later reads of other words of that block hit.
- R5: Miss fills go to buffer 0, buffer 1, buffer 0 and so on. The two most recently filled blocks stay resident, and a third distinct miss evicts the older one.
- R6: A write snoop whose address lies in a buffered block clears only that word's valid bit. A later read of that word misses and returns the new memory data; the other words of the block still hit.
- R7: While `rs_valid` is high and `rs_ready` is low, `rs_valid` and `rs_data` hold and `rq_ready` stays low.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold.
- R9: Burst words are taken one per `mem_rd_valid` cycle at offsets 0 to BURST-1 in order. The requested word is recognised at any offset, including the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request accepted when high with rq_valid |
| rq_addr | input | AW | Word address of the read |
| rs_valid | output | 1 | Read response valid |
| rs_ready | input | 1 | Requester takes the response |
| rs_data | output | DW | Read response data |
| wr_valid | input | 1 | A write to memory is taking place |
| wr_addr | input | AW | Word address of that write |
| mem_req_valid | output | 1 | Burst read request valid |
| mem_req_ready | input | 1 | Memory side accepts the burst request |
| mem_req_addr | output | AW | Burst-aligned word address |
| mem_rd_valid | input | 1 | A burst data word is present |
| mem_rd_data | input | DW | Burst data word |

## Verification
The bench builds the block with AW=8, BURST=4 and DW=32, which gives 64 blocks of four words. This small size lets it sweep every address of the first eight blocks. It also places a miss at each of the four offsets, to cover forwarding from the first, middle and last beat.

With only two buffers, a third distinct block shows eviction and fill alternation within a few reads. A bench-side model of bases, valid bits and fill pointer predicts every hit and miss and counts the memory requests. Stalls on the memory request, response back-pressure and write snoops are mixed into the sweep.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int NBUF = 2;
  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_REQ  = 2'd1,
    PF_FILL = 2'd2
  } pf_state_e;
endpackage

// File: rtl/pf_bank.sv
module pf_bank #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int BURST = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            lk_addr,
  output logic                     lk_hit,
  output logic [DW-1:0]            lk_data,
  input  logic                     fill_start,
  input  logic [AW-$clog2(BURST)-1:0] fill_blk,
  input  logic                     fill_we,
  input  logic [$clog2(BURST)-1:0] fill_idx,
  input  logic [DW-1:0]            fill_data,
  input  logic                     snoop_valid,
  input  logic [AW-1:0]            snoop_addr
);
  localparam int OFFW = $clog2(BURST);
  localparam int BLKW = AW - OFFW;

  logic [BLKW-1:0]  base_q;
  logic [BURST-1:0] valid_q;
  logic [DW-1:0]    word_q [BURST];

  logic snoop_match;
  assign snoop_match = snoop_valid && (snoop_addr[AW-1:OFFW] == base_q);

  assign lk_hit  = (lk_addr[AW-1:OFFW] == base_q) && valid_q[lk_addr[OFFW-1:0]];
  assign lk_data = word_q[lk_addr[OFFW-1:0]];

  // Tag and valid vector; a snoop clear is applied last so it wins over a fill.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      valid_q <= '0;
    end else begin
      if (fill_start) begin
        base_q  <= fill_blk;
        valid_q <= '0;
      end
      if (fill_we) valid_q[fill_idx] <= 1'b1;
      if (snoop_match) valid_q[snoop_addr[OFFW-1:0]] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) word_q[fill_idx] <= fill_data;
  end

  AST_SNOOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_match && !fill_start) |=> !valid_q[$past(snoop_addr[OFFW-1:0])]); // R6

  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !snoop_match) |=> valid_q[$past(fill_idx)]); // R4
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int BURST = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rq_valid,
  input  logic [AW-1:0]                 rq_addr,
  output logic                          rq_ready,
  input  logic                          rs_ready,
  output logic                          rs_valid,
  output logic [DW-1:0]                 rs_data,
  input  logic [NBUF-1:0]               hit,
  input  logic [NBUF-1:0][DW-1:0]       bdata,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [AW-1:0]                 mem_req_addr,
  input  logic                          mem_rd_valid,
  input  logic [DW-1:0]                 mem_rd_data,
  output logic [NBUF-1:0]               fill_start,
  output logic [NBUF-1:0]               fill_we,
  output logic [AW-$clog2(BURST)-1:0]   fill_blk,
  output logic [$clog2(BURST)-1:0]      fill_idx,
  output logic [DW-1:0]                 fill_data
);
  localparam int OFFW = $clog2(BURST);
  localparam logic [OFFW-1:0] LAST = OFFW'(BURST - 1);

  pf_state_e         state_q;
  logic [AW-1:0]     miss_q;
  logic [OFFW-1:0]   beat_q;
  logic              ptr_q;
  logic              rsv_q;
  logic [DW-1:0]     rsd_q;

  logic              accept, any_hit, beat_take, want_word;
  logic [DW-1:0]     hit_data;

  assign rq_ready      = (state_q == PF_IDLE) && !rsv_q;
  assign accept        = rq_valid && rq_ready;
  assign rs_valid      = rsv_q;
  assign rs_data       = rsd_q;
  assign mem_req_valid = (state_q == PF_REQ);
  assign mem_req_addr  = {miss_q[AW-1:OFFW], {OFFW{1'b0}}};
  assign fill_blk      = miss_q[AW-1:OFFW];
  assign fill_idx      = beat_q;
  assign fill_data     = mem_rd_data;
  assign beat_take     = (state_q == PF_FILL) && mem_rd_valid;
  assign want_word     = beat_take && (beat_q == miss_q[OFFW-1:0]);

  // Buffer 0 is preferred when both hold the word.
  always_comb begin
    any_hit  = 1'b0;
    hit_data = '0;
    for (int b = 0; b < NBUF; b++) begin
      if (hit[b] && !any_hit) begin
        any_hit  = 1'b1;
        hit_data = bdata[b];
      end
    end
  end

  always_comb begin
    fill_start = '0;
    fill_we    = '0;
    fill_start[ptr_q] = (state_q == PF_REQ) && mem_req_ready;
    fill_we[ptr_q]    = beat_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PF_IDLE;
      miss_q  <= '0;
      beat_q  <= '0;
      ptr_q   <= 1'b0;
      rsv_q   <= 1'b0;
      rsd_q   <= '0;
    end else begin
      if (rsv_q && rs_ready) rsv_q <= 1'b0;
      unique case (state_q)
        PF_IDLE: begin
          if (accept && any_hit) begin
            rsv_q <= 1'b1;
            rsd_q <= hit_data;
          end else if (accept) begin
            miss_q  <= rq_addr;
            state_q <= PF_REQ;
          end
        end
        PF_REQ: begin
          if (mem_req_ready) begin
            beat_q  <= '0;
            state_q <= PF_FILL;
          end
        end
        PF_FILL: begin
          if (want_word) begin
            rsv_q <= 1'b1;
            rsd_q <= mem_rd_data;
          end
          if (beat_take) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST) begin
              state_q <= PF_IDLE;
              ptr_q   <= ~ptr_q;
            end
          end
        end
        default: state_q <= PF_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data) && !rq_ready)); // R7

  AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_take && beat_q == LAST) |=> (ptr_q != $past(ptr_q))); // R5
endmodule

// File: rtl/rd_prefetch_pair.sv
module rd_prefetch_pair
  import pf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int BURST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rq_valid,
  output logic          rq_ready,
  input  logic [AW-1:0] rq_addr,
  output logic          rs_valid,
  input  logic          rs_ready,
  output logic [DW-1:0] rs_data,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data
);
  localparam int OFFW = $clog2(BURST);
  localparam int BLKW = AW - OFFW;

  logic [NBUF-1:0]         hit, fill_start, fill_we;
  logic [NBUF-1:0][DW-1:0] bdata;
  logic [BLKW-1:0]         fill_blk;
  logic [OFFW-1:0]         fill_idx;
  logic [DW-1:0]           fill_data;

  pf_ctrl #(.AW(AW), .DW(DW), .BURST(BURST)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_ready(rq_ready),
    .rs_ready(rs_ready), .rs_valid(rs_valid), .rs_data(rs_data),
    .hit(hit), .bdata(bdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .fill_start(fill_start), .fill_we(fill_we), .fill_blk(fill_blk),
    .fill_idx(fill_idx), .fill_data(fill_data)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    pf_bank #(.AW(AW), .DW(DW), .BURST(BURST)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(rq_addr), .lk_hit(hit[b]), .lk_data(bdata[b]),
      .fill_start(fill_start[b]), .fill_blk(fill_blk),
      .fill_we(fill_we[b]), .fill_idx(fill_idx), .fill_data(fill_data),
      .snoop_valid(wr_valid), .snoop_addr(wr_addr)
    );
  end

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready && (|hit)) |=> !mem_req_valid); // R2

  AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_we) && $onehot0(fill_start)); // R5

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> (mem_req_addr[AW-1:OFFW] == $past(rq_addr[AW-1:OFFW]))); // R3
endmodule

// File: tb/test_rd_prefetch_pair.sv
module test_rd_prefetch_pair;
  localparam int AW = 8, DW = 32, BURST = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rq_valid = 1'b0, rs_ready = 1'b1, wr_valid = 1'b0;
  logic mem_req_ready = 1'b0, mem_rd_valid = 1'b0;
  logic [AW-1:0] rq_addr = '0, wr_addr = '0;
  logic [DW-1:0] mem_rd_data = '0;
  logic rq_ready, rs_valid, mem_req_valid;
  logic [DW-1:0] rs_data;
  logic [AW-1:0] mem_req_addr;

  int checks = 0, errors = 0, req_count = 0, stall_left = 0;
  int cur_addr = 0;
  bit finished = 0;
  logic [7:0] gen [256];
  int  mbase [2];
  bit  mvalid [2][4];
  int  mptr;

  always #10 clk = ~clk;

  rd_prefetch_pair #(.AW(AW), .DW(DW), .BURST(BURST)) i_rd_prefetch_pair (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [DW-1:0] md(input int a);
    return {8'hA5, gen[a], 8'h3C, 8'(a)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_hit(input int a);
    for (int b = 0; b < 2; b++)
      if (mbase[b] == a / 4 && mvalid[b][a % 4]) return 1'b1;
    return 1'b0;
  endfunction

  // Memory side: optional request stall, then a burst two cycles later.
  initial begin
    int prev;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        if (stall_left > 0) begin
          if (stall_left < 3)
            chk(mem_req_addr == 8'(prev), "R8 request addr held", mem_req_addr, prev);
          prev = mem_req_addr;
          mem_req_ready = 1'b0;
          stall_left--;
        end else begin
          int base;
          base = mem_req_addr;
          req_count++;
          chk(base == (cur_addr / 4) * 4, "R3 aligned burst addr", base, (cur_addr / 4) * 4);
          mem_req_ready = 1'b1;
          @(negedge clk);
          mem_req_ready = 1'b0;
          @(negedge clk);
          for (int k = 0; k < BURST; k++) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = md(base + k);
            @(negedge clk);
          end
          mem_rd_valid = 1'b0;
        end
      end
    end
  end

  task automatic do_read(input int a, input bit hold);
    bit exp_hit;
    int rc0, n;
    logic [DW-1:0] exp;
    exp_hit = model_hit(a);
    exp = md(a);
    rc0 = req_count;
    cur_addr = a;
    rq_addr = 8'(a);
    rq_valid = 1'b1;
    while (!rq_ready) @(negedge clk);
    @(negedge clk);
    rq_valid = 1'b0;
    n = 0;
    while (!rs_valid && n < 60) begin @(negedge clk); n++; end
    chk(rs_data == exp, exp_hit ? "R2 hit data" : "R4 miss forwarded data", rs_data, exp);
    if (exp_hit)
      chk(n == 0 && req_count == rc0, "R2 hit latency and no request", n, 0);
    else
      chk(req_count == rc0 + 1, "R3 one burst request per miss", req_count - rc0, 1);
    if (!exp_hit) begin
      mbase[mptr] = a / 4;
      for (int k = 0; k < 4; k++) mvalid[mptr][k] = 1'b1;
      mptr ^= 1;
    end
    if (hold) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(rs_valid && rs_data == exp && !rq_ready, "R7 response held", rs_data, exp);
      end
      rs_ready = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic do_write(input int a);
    wr_addr = 8'(a);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    gen[a] = gen[a] + 8'd1;
    for (int b = 0; b < 2; b++)
      if (mbase[b] == a / 4) mvalid[b][a % 4] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) gen[i] = 8'(i * 7);
    for (int b = 0; b < 2; b++) begin
      mbase[b] = 0;
      for (int k = 0; k < 4; k++) mvalid[b][k] = 1'b0;
    end
    mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rq_ready && !rs_valid && !mem_req_valid, "R1 reset outputs",
        {rq_ready, rs_valid, mem_req_valid}, 3'b100);

    // R1 R4 R5 R9: sweep eight blocks word by word.
    for (int a = 0; a < 32; a++) do_read(a, 1'b0);
    // R5: last two blocks resident, then evictions.
    do_read(24, 1'b0); do_read(29, 1'b0); do_read(0, 1'b0);
    do_read(28, 1'b0); do_read(25, 1'b0); do_read(3, 1'b0);
    // R9: a miss at every offset, then the rest of each block.
    for (int o = 0; o < 4; o++) begin
      for (int w = 0; w < 4; w++) do_read(40 + o * 4 + ((o + w) % 4), 1'b0);
    end
    // R6: snoops clear single words.
    do_write(54);
    do_read(53, 1'b0); do_read(55, 1'b0); do_read(54, 1'b0); do_read(54, 1'b0);
    do_write(200);
    do_read(52, 1'b0);
    // R8: stalled burst request.
    stall_left = 4;
    do_read(100, 1'b0);
    do_read(101, 1'b0);
    // R7: back-pressure on a hit and on a miss.
    rs_ready = 1'b0;
    do_read(102, 1'b1);
    rs_ready = 1'b0;
    do_read(150, 1'b1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule